// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory with one shared bidirectional data bus, built so that reads and writes can follow each other on every clock with no idle cycle between them. Each access is set up on one rising edge (the address edge). A read returns its word from an output register after the next edge. A write takes its data and byte selects from the bus on the second edge after its address edge. Because both directions use the same two-edge latency, the bus never needs a turnaround gap. Each byte lane carries eight data bits and one parity bit. The bus is brought out as separate input, output and drive-enable ports.

An active-low clock enable freezes the whole pipeline. Three chip enables (two active-low, one active-high) select the part. An advance/load strobe either loads a fresh address or steps a short burst through the lowest two address bits. An asynchronous active-low output enable gates the drivers. A write that is still waiting for its data is forwarded into a read of the same word that is started on the next edge. That read therefore returns the newly written lanes, merged with the old lanes that were not selected.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the pipeline empties and every word is cleared. After reset, `bus_oe` is low and every word reads as zero.
- R2: On an edge where `cen_n` is high, nothing advances. The output register, the drive state and the memory keep their values, and no write data is taken.
- R3: A load edge with `cen_n` low, `ce0_n` low, `ce1` high, `ce2_n` low, `adv_ld_n` low and `we_n` high starts a read. Its word is on `bus_out` after the next enabled edge. `bus_oe` is high for that word only while `oe_n` is low.
- R4: The same load edge with `we_n` low starts a write. After the next enabled edge, `bus_oe` stays low whatever the level of `oe_n`. `bus_in` and `bsel_n` are taken on the enabled edge after that one.
- R5: Lane `b` covers bits `b*9+8 : b*9`. A write changes lane `b` only when `bsel_n[b]` is low at its data edge. All other lanes keep their contents.
- R6: A new read, write or deselect can be loaded on every enabled edge. A read loaded on the edge after a write to the same word returns that write's selected lanes, merged with the old unselected lanes.
- R7: A load edge with any chip enable inactive deselects the part. After the next enabled edge, `bus_oe` is low, and no word is written for that slot.
- R8: An enabled edge with `adv_ld_n` high after a read or write continues the same operation. Address bits [1:0] advance by one, wrapping from 3 to 0, and the upper bits stay fixed. `we_n` and the chip enables are ignored on such edges.
- R9: An enabled edge with `adv_ld_n` high while the part is deselected keeps it deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low; high stalls everything |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low loads a new access; high advances the burst |
| we_n | input | 1 | Low selects write at a load edge |
| bsel_n | input | NBYTES | Per-lane write selects, active low, taken at the data edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| bus_in | input | NBYTES*BYTE_W | Data arriving from the shared bus |
| bus_out | output | NBYTES*BYTE_W | Data from the output register |
| bus_oe | output | 1 | High when the block drives the shared bus |

## Verification
The assertions assume that `rst` is high on the first edge. They also assume that the bus is driven only from outside while `bus_oe` is low. The stimulus holds reset over the first edges and changes every input only just after a rising edge. It models the bus as two separate directions, so contention cannot arise. The random stream keeps addresses within eight words so that writes followed by reads of the same word happen often. It mixes in deselects, burst advances and stalls in all pipeline positions, and the directed sequences place stalls inside write data phases and read output windows.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Operation held in each pipeline slot
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } slot_op_e;

    // Number of low address bits stepped by a burst
    localparam int unsigned BURST_BITS = 2;

    // Next burst lane: linear, wrapping inside the burst window
    function automatic logic [BURST_BITS-1:0] burst_next(input logic [BURST_BITS-1:0] lane);
        return lane + {{(BURST_BITS-1){1'b0}}, 1'b1};
    endfunction

    // Decode of the three chip enables
    function automatic logic chip_selected(input logic c0_n, input logic c1, input logic c2_n);
        return !c0_n && c1 && !c2_n;
    endfunction

endpackage

// File: rtl/zt_sram_load.sv
module zt_sram_load
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output slot_op_e          s1_op,
    output logic [ADDR_W-1:0] s1_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_BITS;

    slot_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sel;

    assign sel = chip_selected(ce0_n, ce1, ce2_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else if (!cen_n) begin
            if (!adv_ld_n) begin
                if (sel) begin
                    op_q   <= we_n ? OP_READ : OP_WRITE;
                    addr_q <= addr;
                end else begin
                    op_q   <= OP_IDLE;
                end
            end else if (op_q != OP_IDLE) begin
                addr_q <= {addr_q[ADDR_W-1 -: HI_W], burst_next(addr_q[BURST_BITS-1:0])};
            end
        end
    end

    assign s1_op   = op_q;
    assign s1_addr = addr_q;

    AST_DESEL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld_n && op_q == OP_IDLE) |=> (op_q == OP_IDLE)) // R9
        else $error("AST_DESEL_STAYS");

    AST_CE_IGNORED_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld_n && op_q != OP_IDLE) |=> (op_q == $past(op_q))) // R8
        else $error("AST_CE_IGNORED_IN_BURST");

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cen_n,
    input  slot_op_e                 s1_op,
    input  logic [ADDR_W-1:0]        s1_addr,
    input  logic [NBYTES-1:0]        bsel_n,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rd_q,
    output logic                     rd_vld
);

    localparam int unsigned DATA_W = NBYTES * BYTE_W;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    slot_op_e          s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;
    logic              fwd_hit;

    assign old_word = mem[s2_addr];

    // Lane merge of the pending write with the stored word
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign wr_word[b*BYTE_W +: BYTE_W] = bsel_n[b] ? old_word[b*BYTE_W +: BYTE_W]
                                                       : wdata[b*BYTE_W +: BYTE_W];
    end

    // Read of the word being written on the same edge takes the merged value
    assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);
    assign rd_word = fwd_hit ? wr_word : mem[s1_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            rd_vld  <= 1'b0;
            rd_q    <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (!cen_n) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            rd_vld  <= (s1_op == OP_READ);
            if (s1_op == OP_READ) begin
                rd_q <= rd_word;
            end
            if (s2_op == OP_WRITE) begin
                mem[s2_addr] <= wr_word;
            end
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (!rd_vld && s2_op == OP_IDLE)) // R1
        else $error("AST_RESET_EMPTY");

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(rd_q) && $stable(rd_vld) && $stable(s2_op) && $stable(s2_addr))) // R2
        else $error("AST_STALL_HOLD");

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && s1_op == OP_READ) |=> rd_vld) // R3
        else $error("AST_READ_LATENCY");

    AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && s1_op == OP_WRITE) |=> !rd_vld) // R4
        else $error("AST_WRITE_RELEASE");

    AST_DESEL_PIPE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && s1_op == OP_IDLE) |=> !rd_vld) // R7
        else $error("AST_DESEL_PIPE");

    AST_SLOT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!cen_n) |=> (s2_op == $past(s1_op) && s2_addr == $past(s1_addr))) // R6
        else $error("AST_SLOT_SHIFT");

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cen_n,
    input  logic                     ce0_n,
    input  logic                     ce1,
    input  logic                     ce2_n,
    input  logic                     adv_ld_n,
    input  logic                     we_n,
    input  logic [NBYTES-1:0]        bsel_n,
    input  logic                     oe_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] bus_in,
    output logic [NBYTES*BYTE_W-1:0] bus_out,
    output logic                     bus_oe
);

    slot_op_e          s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic              rd_vld;

    zt_sram_load #(
        .ADDR_W (ADDR_W)
    ) i_load (
        .clk      (clk),
        .rst      (rst),
        .cen_n    (cen_n),
        .ce0_n    (ce0_n),
        .ce1      (ce1),
        .ce2_n    (ce2_n),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .addr     (addr),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr)
    );

    zt_sram_core #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) i_core (
        .clk     (clk),
        .rst     (rst),
        .cen_n   (cen_n),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .bsel_n  (bsel_n),
        .wdata   (bus_in),
        .rd_q    (bus_out),
        .rd_vld  (rd_vld)
    );

    // Output enable acts without a clock on the drivers
    assign bus_oe = rd_vld && !oe_n;

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld_n && s1_op != OP_IDLE) |=>
        (s1_addr[BURST_BITS-1:0] == $past(s1_addr[BURST_BITS-1:0]) + 2'd1 &&
         s1_addr[ADDR_W-1:BURST_BITS] == $past(s1_addr[ADDR_W-1:BURST_BITS]))) // R8
        else $error("AST_BURST_STEP");

endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int OP_I = 0;
    localparam int OP_R = 1;
    localparam int OP_W = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cen_n, ce0_n, ce1, ce2_n, adv_ld_n, we_n, oe_n;
    logic [NB-1:0] bsel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] bus_in;
    logic [DW-1:0] bus_out;
    logic          bus_oe;

    zt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) i_zt_sram (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .adv_ld_n(adv_ld_n), .we_n(we_n), .bsel_n(bsel_n), .oe_n(oe_n), .addr(addr),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference memory and its two-slot pipeline
    logic [DW-1:0] ref_mem [1 << AW];
    int            m_op1, m_op2;
    logic [AW-1:0] m_a1, m_a2;
    logic          exp_v;
    logic [DW-1:0] exp_d;

    // Scoreboard
    logic          q_v[$];
    logic [DW-1:0] q_d[$];
    string         q_tag[$];

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    task automatic check(input string tag, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one expectation per clock, sampled at the falling edge
    always @(negedge clk) begin
        if (q_v.size() > 0) begin
            logic          v;
            logic [DW-1:0] d;
            string         t;
            v = q_v.pop_front();
            d = q_d.pop_front();
            t = q_tag.pop_front();
            check(t, bus_oe == (v && !oe_n), {35'd0, bus_oe}, {35'd0, v && !oe_n});
            if (v && !oe_n) check(t, bus_out === d, bus_out, d);
        end
    end

    // One clock: drive inputs, take the edge, update the reference, push expectation
    task automatic step(input bit cen_v, input bit sel_v, input bit adv_v, input bit we_v,
                        input logic [AW-1:0] ad, input logic [NB-1:0] bs, input bit oe_v,
                        input string tag);
        cen_n    = cen_v;
        adv_ld_n = adv_v;
        we_n     = we_v;
        addr     = ad;
        bsel_n   = bs;
        oe_n     = oe_v;
        bus_in   = {$urandom(), $urandom()};
        if (sel_v) begin
            ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0;
        end else begin
            int k;
            k = $urandom_range(2);
            ce0_n = $urandom_range(1); ce1 = $urandom_range(1); ce2_n = $urandom_range(1);
            if (k == 0) ce0_n = 1'b1;
            else if (k == 1) ce1 = 1'b0;
            else ce2_n = 1'b1;
        end
        @(posedge clk);
        #1;
        if (!cen_v) begin
            if (m_op2 == OP_W)
                for (int b = 0; b < NB; b++)
                    if (!bs[b]) ref_mem[m_a2][b*BW +: BW] = bus_in[b*BW +: BW];
            exp_v = (m_op1 == OP_R);
            if (exp_v) exp_d = ref_mem[m_a1];
            m_op2 = m_op1;
            m_a2  = m_a1;
            if (!adv_v) begin
                if (sel_v) begin
                    m_op1 = we_v ? OP_R : OP_W;
                    m_a1  = ad;
                end else begin
                    m_op1 = OP_I;
                end
            end else if (m_op1 != OP_I) begin
                m_a1[1:0] = m_a1[1:0] + 2'd1;
            end
        end
        q_v.push_back(exp_v);
        q_d.push_back(exp_d);
        q_tag.push_back(tag);
    endtask

    task automatic rd(input logic [AW-1:0] ad, input string tag);
        step(0, 1, 0, 1, ad, 4'hF, 0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] ad, input logic [NB-1:0] bs, input string tag);
        step(0, 1, 0, 0, ad, bs, 0, tag);
    endtask

    task automatic nop(input string tag);
        step(0, 0, 0, 1, '0, 4'hF, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cen_n = 1'b0; ce0_n = 1'b1; ce1 = 1'b0; ce2_n = 1'b1;
        adv_ld_n = 1'b0; we_n = 1'b1; bsel_n = '1; oe_n = 1'b0; addr = '0; bus_in = '0;
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        m_op1 = OP_I; m_op2 = OP_I; m_a1 = '0; m_a2 = '0; exp_v = 1'b0; exp_d = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: drivers off after reset even with oe_n low
        check("R1 reset drive", bus_oe == 1'b0, {35'd0, bus_oe}, '0);
        @(posedge clk); #1;

        // R1: cleared words read zero
        rd(6'd0, "R1"); rd(6'd37, "R1"); nop("R1"); nop("R1");

        // R3/R4: write full word, read it back; oe_n high hides the read word
        wr(6'd3, 4'h0, "R4"); nop("R4"); nop("R4");
        rd(6'd3, "R3"); step(0, 0, 0, 1, '0, 4'hF, 1, "R3 oe high"); nop("R3");
        rd(6'd3, "R3"); nop("R3");

        // R4: write data phase with oe_n low keeps the bus released
        wr(6'd9, 4'h0, "R4"); nop("R4 release"); nop("R4"); rd(6'd9, "R4"); nop("R4");

        // R5: partial write lanes 0 and 2 only
        wr(6'd3, 4'b1010, "R5"); nop("R5"); nop("R5"); rd(6'd3, "R5"); nop("R5");

        // R6: back-to-back write then read of the same word (forwarding)
        wr(6'd3, 4'b0110, "R6"); rd(6'd3, "R6 fwd"); wr(6'd4, 4'h0, "R6");
        rd(6'd4, "R6 fwd"); rd(6'd3, "R6"); nop("R6"); nop("R6");

        // R7: read then deselect; write with a chip enable off stores nothing
        rd(6'd3, "R7"); nop("R7 desel"); nop("R7");
        step(0, 0, 0, 0, 6'd3, 4'h0, 0, "R7"); nop("R7"); nop("R7");
        rd(6'd3, "R7 no write"); nop("R7");

        // R8: burst write from lane 2 with chip enables off and we_n high ignored
        wr(6'd6, 4'h0, "R8");
        step(0, 0, 1, 1, 6'd0, 4'h0, 0, "R8");
        step(0, 0, 1, 1, 6'd0, 4'h0, 0, "R8");
        step(0, 0, 1, 1, 6'd0, 4'h0, 0, "R8");
        nop("R8"); nop("R8");
        // R8: burst read wraps 6,7,4,5 with we_n low ignored
        rd(6'd6, "R8");
        step(0, 0, 1, 0, 6'd0, 4'hF, 0, "R8");
        step(0, 0, 1, 0, 6'd0, 4'hF, 0, "R8");
        step(0, 0, 1, 0, 6'd0, 4'hF, 0, "R8 wrap");
        nop("R8"); nop("R8");

        // R9: deselect then advance stays deselected
        nop("R9"); step(0, 1, 1, 1, 6'd6, 4'hF, 0, "R9");
        step(0, 1, 1, 1, 6'd6, 4'hF, 0, "R9"); nop("R9");

        // R2: stall during read output and during write data phase
        rd(6'd6, "R2"); step(1, 1, 0, 0, 6'd7, 4'h0, 0, "R2 hold");
        step(1, 0, 0, 0, 6'd7, 4'h0, 0, "R2 hold"); nop("R2");
        wr(6'd7, 4'h0, "R2"); nop("R2");
        step(1, 1, 0, 1, 6'd7, 4'h0, 0, "R2 no take");
        nop("R2"); nop("R2"); rd(6'd7, "R2"); nop("R2");

        // R6: random mix of all operations and stalls
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(99);
            step(r < 8, $urandom_range(9) != 0, $urandom_range(3) == 0, $urandom_range(1),
                 AW'($urandom_range(7)), NB'($urandom()), $urandom_range(7) == 0, "R6 random");
        end
        nop("R6"); nop("R6");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule